// File: doc/BRIEF.md
# DMA Channel Request Generator

This block decides, one clock at a time, whether a single DMA channel should ask for the internal bus. It also decides whether the channel should keep the bus for another operand or hand it back. It handles four request sources, chosen by a 2-bit mode field:

- **Always-on internal:** requests without pause.
- **Duty-capped internal:** limited to a share of every 1024-cycle window.
- **Level-held external:** driven by a peripheral that holds its request line low.
- **Pulsed external:** driven by a peripheral that sends one low pulse per operand.

The address generator, byte counter and data path sit outside the block. They report through simple strobes: `op_done` marks the last cycle of an operand and `blk_done` marks the end of the whole block. The bus arbiter answers `bus_req` with `bus_grant`. The data mover reports which half of the operand is running on `bus_phase_wr` (0 = read cycle at the source, 1 = write cycle at the destination). For external sources the block raises an acknowledge during the half that belongs to the requesting device.

Every pin is plain control or status. Nothing streams through the block, so there is no valid/ready pairing and no back-pressure.

Top module: `dma_req_gen`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `dack`, `dack_wr` and `bus_release` are all low.
- R2: In mode 0 (always-on), once `cfg_start` is high the channel requests, keeps the bus, and runs operands back to back. It stops only on `cfg_start` falling or on `blk_done`.
- R3: In mode 1 (duty-capped), a free-running 1024-cycle window starts counting at reset release. Bus-owned cycles per window are limited by `cfg_bw`: codes 0 and 1 allow 256, code 2 allows 512, code 3 allows 768. A tenure ends at the first operand end where the owned count reaches the limit. No request is raised again until the next window begins.
- R4: In modes 2 and 3 (external), no request is raised unless `cfg_start` is high and the active-low `dreq_n` has been recognised first.
- R5: `dack` is high only while the bus is owned in an external mode, and only in the half selected by `cfg_ack_dst` (0 = read half, `bus_phase_wr`=0; 1 = write half, `bus_phase_wr`=1). `dack_wr` equals `bus_phase_wr` whenever `dack` is high and is low otherwise.
- R6: In mode 2 (level-held), `dreq_n` passes through a 2-flop synchroniser and is sampled in every `dack` cycle of an operand. If any of those samples sees the request active, the next operand follows without releasing the bus.
- R7: In mode 2, if none of an operand's `dack`-cycle samples sees the request active, the bus is released at the end of that operand.
- R8: In mode 3 (pulsed), a low pulse counts only if the synchronised request is seen active at two consecutive falling clock edges. Each counted pulse yields exactly one operand, after which the bus is released. A pulse that spans only one falling edge is ignored.
- R9: In mode 3, any number of pulses counted while a transfer is in flight collapse into one pending request, which produces exactly one more operand.
- R10: `cfg_start` low or `blk_done` high drops `bus_req` in the next cycle and discards any pending pulse. After `blk_done`, no request is raised until `cfg_start` has been cleared.
- R11: `bus_release` is a single-cycle strobe in the last owned cycle of a tenure, and `bus_req` is low in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start | input | 1 | Channel enable |
| cfg_mode | input | 2 | Request source: 0 always-on, 1 duty-capped, 2 level-held, 3 pulsed |
| cfg_bw | input | 2 | Duty-cap code for mode 1 |
| cfg_ack_dst | input | 1 | 0 = acknowledge in read half, 1 = acknowledge in write half |
| dreq_n | input | 1 | Asynchronous peripheral request, active low |
| bus_grant | input | 1 | Arbiter grant, held for the whole tenure |
| bus_phase_wr | input | 1 | Current operand half: 0 read, 1 write |
| op_done | input | 1 | Last cycle of the current operand |
| blk_done | input | 1 | Whole block finished; one-cycle strobe |
| bus_req | output | 1 | Bus request, held from request through ownership |
| dack | output | 1 | Acknowledge to the requesting peripheral |
| dack_wr | output | 1 | Qualifies `dack` as belonging to the write half |
| bus_release | output | 1 | Strobe: the channel gives the bus back |

## Verification
The properties assume three things about the surrounding logic. The arbiter keeps `bus_grant` high for as long as `bus_req` stays high once it has granted. `op_done` and `bus_phase_wr` only move while the bus is owned. The mode, duty-cap and acknowledge-side fields change only while `bus_req` is low. The stimulus keeps within these limits in two ways: a small arbiter-and-data-mover model grants one cycle after a request, walks a fixed-length operand and drops the grant as soon as the request falls; and every configuration change is made while the channel is idle. Peripheral pulses are driven with whole-cycle widths, so each pulse covers a known number of falling edges after synchronisation.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // request source selected by the 2-bit mode field
  typedef enum logic [1:0] {
    SRC_FULL   = 2'd0,
    SRC_CAPPED = 2'd1,
    SRC_LEVEL  = 2'd2,
    SRC_PULSE  = 2'd3
  } req_src_e;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_ASK  = 2'd1,
    CH_OWN  = 2'd2
  } ch_state_e;

endpackage

// File: rtl/dma_req_sync.sv
// Synchroniser for the peripheral request line, plus the two-falling-edge
// qualifier used by the pulsed mode.
module dma_req_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq_n,
  output logic dreq_act,
  output logic pulse_hit
);

  logic [SYNC_LEN-1:0] chain_q;
  logic fe_smp_q, fe_prev_q, fe_lock_q;

  generate
    if (SYNC_LEN == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= dreq_n;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[SYNC_LEN-2:0], dreq_n};
      end
    end
  endgenerate

  assign dreq_act = ~chain_q[SYNC_LEN-1];

  // capture at the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fe_smp_q <= 1'b0;
    else        fe_smp_q <= dreq_act;
  end

  // fe_prev_q holds the sample of the falling edge before fe_smp_q
  assign pulse_hit = fe_smp_q & fe_prev_q & ~fe_lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_prev_q <= 1'b0;
      fe_lock_q <= 1'b0;
    end else begin
      fe_prev_q <= fe_smp_q;
      fe_lock_q <= fe_smp_q ? (fe_lock_q | pulse_hit) : 1'b0;
    end
  end

endmodule

// File: rtl/dma_req_throttle.sv
// Free-running window and owned-cycle counter for the duty-capped mode.
module dma_req_throttle #(
  parameter int WIN_LEN = 1024,
  parameter int CNT_W   = $clog2(WIN_LEN) + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bw_sel,
  input  logic       owned,
  output logic       under_quota,
  output logic       room_after
);

  localparam int WIN_W   = $clog2(WIN_LEN);
  localparam int QUARTER = WIN_LEN / 4;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] used_q, quota;
  logic             wrap;

  assign wrap = (win_q == WIN_W'(WIN_LEN - 1));

  always_comb begin
    case (bw_sel)
      2'd2:    quota = CNT_W'(QUARTER * 2);
      2'd3:    quota = CNT_W'(QUARTER * 3);
      default: quota = CNT_W'(QUARTER);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      used_q <= '0;
    end else begin
      win_q  <= wrap ? '0 : win_q + 1'b1;
      if (wrap)       used_q <= '0;
      else if (owned) used_q <= used_q + 1'b1;
    end
  end

  assign under_quota = used_q < quota;
  assign room_after  = (used_q + 1'b1) < quota;

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int WIN_LEN  = 1024,
  parameter int SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_start,
  input  logic [1:0] cfg_mode,
  input  logic [1:0] cfg_bw,
  input  logic       cfg_ack_dst,
  input  logic       dreq_n,
  input  logic       bus_grant,
  input  logic       bus_phase_wr,
  input  logic       op_done,
  input  logic       blk_done,
  output logic       bus_req,
  output logic       dack,
  output logic       dack_wr,
  output logic       bus_release
);

  localparam int CNT_W = $clog2(WIN_LEN) + 1;

  req_src_e  mode;
  ch_state_e st_q, st_d;

  logic dreq_act, pulse_hit, under_quota, room_after;
  logic fin_q, pend_q, keep_q;
  logic run_now, want, owned, cont, keep_now, ask_hold, grant_take, stop_now, ext_mode;

  assign mode = req_src_e'(cfg_mode);

  dma_req_sync #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq_n    (dreq_n),
    .dreq_act  (dreq_act),
    .pulse_hit (pulse_hit)
  );

  dma_req_throttle #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_thr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bw_sel      (cfg_bw),
    .owned       (owned),
    .under_quota (under_quota),
    .room_after  (room_after)
  );

  always_comb begin
    run_now  = cfg_start & ~fin_q & ~blk_done;
    owned    = (st_q == CH_OWN);
    ext_mode = cfg_mode[1];
    dack     = owned & ext_mode & (bus_phase_wr == cfg_ack_dst);
    dack_wr  = dack & bus_phase_wr;
    keep_now = keep_q | (dack & dreq_act);

    case (mode)
      SRC_FULL:   want = 1'b1;
      SRC_CAPPED: want = under_quota;
      SRC_LEVEL:  want = dreq_act;
      SRC_PULSE:  want = pend_q;
      default:    want = 1'b0;
    endcase

    case (mode)
      SRC_FULL:   cont = 1'b1;
      SRC_CAPPED: cont = room_after;
      SRC_LEVEL:  cont = keep_now;
      default:    cont = 1'b0;
    endcase

    ask_hold = ((mode == SRC_CAPPED) & ~under_quota) |
               ((mode == SRC_LEVEL) & ~dreq_act);
    stop_now = owned & (~run_now | (op_done & ~cont));

    st_d = st_q;
    case (st_q)
      CH_IDLE: if (run_now && want) st_d = CH_ASK;
      CH_ASK: begin
        if (!run_now || ask_hold) st_d = CH_IDLE;
        else if (bus_grant)       st_d = CH_OWN;
      end
      CH_OWN:  if (stop_now) st_d = CH_IDLE;
      default: st_d = CH_IDLE;
    endcase

    grant_take = (st_q == CH_ASK) & (st_d == CH_OWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CH_IDLE;
      fin_q  <= 1'b0;
      pend_q <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      st_q <= st_d;

      if (!cfg_start)    fin_q <= 1'b0;
      else if (blk_done) fin_q <= 1'b1;

      if (!run_now)                             pend_q <= 1'b0;
      else if (pulse_hit && mode == SRC_PULSE)  pend_q <= 1'b1;
      else if (grant_take)                      pend_q <= 1'b0;

      if (!owned || op_done)        keep_q <= 1'b0;
      else if (dack && dreq_act)    keep_q <= 1'b1;
    end
  end

  assign bus_req     = (st_q != CH_IDLE);
  assign bus_release = stop_now;

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_start,
  input logic [1:0] cfg_mode,
  input logic       cfg_ack_dst,
  input logic       bus_grant,
  input logic       bus_phase_wr,
  input logic       blk_done,
  input logic       bus_req,
  input logic       dack,
  input logic       dack_wr,
  input logic       bus_release
);

  // R10
  blk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !bus_req);

  // R10
  start_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_start |=> !bus_req);

  // R11
  release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_req);

  // R5
  dack_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_req && bus_grant && cfg_mode[1]));

  // R5
  dack_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (bus_phase_wr == cfg_ack_dst));

  // R5
  dack_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dack_wr |-> dack);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_release && cfg_mode == 2'd0) |-> (!cfg_start || blk_done));

endmodule

bind dma_req_gen dma_req_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_start    (cfg_start),
  .cfg_mode     (cfg_mode),
  .cfg_ack_dst  (cfg_ack_dst),
  .bus_grant    (bus_grant),
  .bus_phase_wr (bus_phase_wr),
  .blk_done     (blk_done),
  .bus_req      (bus_req),
  .dack         (dack),
  .dack_wr      (dack_wr),
  .bus_release  (bus_release)
);

// File: tb/sim_dma_req_gen.sv
module sim_dma_req_gen;
  localparam int CLK_P = 10;
  localparam int WIN   = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_start = 1'b0, cfg_ack_dst = 1'b0, dreq_n = 1'b1;
  logic [1:0] cfg_mode = 2'd0, cfg_bw = 2'd0;
  logic bus_grant = 1'b0, bus_phase_wr = 1'b0, op_done = 1'b0, blk_done = 1'b0;
  logic bus_req, dack, dack_wr, bus_release;

  int n_chk = 0, n_bad = 0, n_pop = 0, ncyc = 0;
  int pc = -1, op_len = 4, cur_ops = 0;
  logic [1:0] cur_mask = 2'b00;
  logic rel_prev = 1'b0;
  int exp_ops[$];
  logic [1:0] exp_mask[$];
  string exp_tag[$];

  always #(CLK_P/2) clk = ~clk;

  dma_req_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
    .cfg_bw(cfg_bw), .cfg_ack_dst(cfg_ack_dst), .dreq_n(dreq_n),
    .bus_grant(bus_grant), .bus_phase_wr(bus_phase_wr), .op_done(op_done),
    .blk_done(blk_done), .bus_req(bus_req), .dack(dack), .dack_wr(dack_wr),
    .bus_release(bus_release)
  );

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();  @(posedge clk); #1; endtask
  task automatic wt();    @(posedge clk); #2; endtask

  task automatic expect_ten(input int ops, input logic [1:0] mask, input string tag);
    exp_ops.push_back(ops);
    exp_mask.push_back(mask);
    exp_tag.push_back(tag);
  endtask

  task automatic quiet(input int n, input string tag);
    int hits = 0;
    repeat (n) begin @(posedge clk); #4; if (bus_req) hits++; end
    chk(hits == 0, tag, "request cycles while no request allowed", hits, 0);
  endtask

  task automatic pulse(input int n);
    step(); dreq_n = 1'b0;
    repeat (n) step();
    dreq_n = 1'b1;
  endtask

  task automatic wait_ops(input int k);
    do wt(); while (!(cur_ops == k && pc == 0 && bus_grant));
  endtask

  task automatic wait_pop(input int n);
    while (n_pop < n) @(posedge clk);
  endtask

  task automatic align();
    do step(); while (ncyc % WIN != 0);
  endtask

  // arbiter and data-mover model
  initial forever begin
    @(posedge clk); #1;
    if (!bus_req) begin
      bus_grant = 1'b0; pc = -1; op_done = 1'b0; bus_phase_wr = 1'b0;
    end else if (!bus_grant) begin
      bus_grant = 1'b1; pc = -1; op_done = 1'b0; bus_phase_wr = 1'b0;
    end else begin
      pc = (pc + 1) % op_len;
      bus_phase_wr = (pc >= op_len / 2);
      op_done = (pc == op_len - 1);
    end
  end

  // monitor: build one record per tenure and compare against the queue
  initial forever begin
    @(posedge clk); #4;
    if (rst_n) begin
      if (rel_prev) chk(!bus_req, "R11", "bus_req after release", int'(bus_req), 0);
      if (bus_req && bus_grant) begin
        if (op_done) cur_ops++;
        if (dack) cur_mask = cur_mask | (dack_wr ? 2'b10 : 2'b01);
      end
      rel_prev = bus_release;
      if (bus_release) begin
        if (exp_ops.size() == 0) begin
          chk(1'b0, "R11", "tenure with nothing expected", cur_ops, -1);
        end else begin
          string t;
          int eo;
          logic [1:0] em;
          eo = exp_ops.pop_front();
          em = exp_mask.pop_front();
          t  = exp_tag.pop_front();
          chk(cur_ops == eo, t, "operands in tenure", cur_ops, eo);
          chk(cur_mask == em, t, "acknowledge half mask", int'(cur_mask), int'(em));
        end
        n_pop++;
        cur_ops = 0;
        cur_mask = 2'b00;
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got 0 expected 1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #4;
    chk(!bus_req, "R1", "bus_req in reset", int'(bus_req), 0);
    chk(!dack, "R1", "dack in reset", int'(dack), 0);
    chk(!dack_wr, "R1", "dack_wr in reset", int'(dack_wr), 0);
    chk(!bus_release, "R1", "bus_release in reset", int'(bus_release), 0);
    step(); rst_n = 1'b1;

    // R2 always-on: five operands then stop by clearing start
    expect_ten(5, 2'b00, "R2");
    step(); cfg_mode = 2'd0; cfg_start = 1'b1;
    wait_ops(5); cfg_start = 1'b0;
    wait_pop(1);
    quiet(5, "R10");

    // R10 block done ends tenure and blocks restart while start stays high
    expect_ten(3, 2'b00, "R10");
    step(); cfg_start = 1'b1;
    wait_ops(3); blk_done = 1'b1;
    step(); blk_done = 1'b0;
    wait_pop(2);
    quiet(12, "R10");
    step(); cfg_start = 1'b0;

    // R4, R6, R7 level-held, read-half acknowledge
    step(); cfg_mode = 2'd2; cfg_ack_dst = 1'b0; cfg_start = 1'b1;
    quiet(20, "R4");
    expect_ten(4, 2'b01, "R6 R7");
    step(); dreq_n = 1'b0;
    do wt(); while (!(cur_ops == 2 && pc == 2 && bus_grant));
    dreq_n = 1'b1;
    wait_pop(3);
    quiet(20, "R7");

    // R5 R7 level-held, write-half acknowledge
    step(); cfg_ack_dst = 1'b1;
    expect_ten(3, 2'b10, "R5 R7");
    step(); dreq_n = 1'b0;
    do wt(); while (!(cur_ops == 1 && pc == 2 && bus_grant));
    dreq_n = 1'b1;
    wait_pop(4);
    quiet(10, "R7");
    step(); cfg_start = 1'b0;

    // R3 duty cap 25%: 256 owned cycles = 64 operands per window
    step(); cfg_mode = 2'd1; cfg_bw = 2'd0; cfg_ack_dst = 1'b0;
    expect_ten(64, 2'b00, "R3");
    expect_ten(64, 2'b00, "R3");
    align(); cfg_start = 1'b1;
    wait_pop(5);
    quiet(200, "R3");
    wait_pop(6);
    do step(); while (ncyc % WIN != 600);
    cfg_start = 1'b0;

    // R3 duty cap 50%: 128 operands
    step(); cfg_bw = 2'd2;
    expect_ten(128, 2'b00, "R3");
    align(); cfg_start = 1'b1;
    wait_pop(7);
    do step(); while (ncyc % WIN != 900);
    cfg_start = 1'b0;

    // R3 duty cap 75%: 192 operands
    step(); cfg_bw = 2'd3;
    expect_ten(192, 2'b00, "R3");
    align(); cfg_start = 1'b1;
    wait_pop(8);
    do step(); while (ncyc % WIN != 900);
    cfg_start = 1'b0;

    // R8 R9 pulsed mode, write-half acknowledge, long operands
    step(); cfg_mode = 2'd3; cfg_ack_dst = 1'b1; op_len = 12; cfg_start = 1'b1;
    pulse(1);
    quiet(15, "R8");
    expect_ten(1, 2'b10, "R8");
    expect_ten(1, 2'b10, "R9");
    pulse(2);
    do wt(); while (!(bus_grant && pc >= 0));
    pulse(2);
    step();
    pulse(2);
    wait_pop(10);
    quiet(20, "R9");

    // R10 clearing start drops a pending pulse
    expect_ten(0, 2'b10, "R10");
    pulse(2);
    do wt(); while (!(bus_grant && pc == 0));
    pulse(2);
    do wt(); while (pc != 8);
    cfg_start = 1'b0;
    step(); cfg_start = 1'b1;
    quiet(20, "R10");
    wait_pop(11);
    step(); cfg_start = 1'b0;

    repeat (4) step();
    chk(exp_ops.size() == 0, "R2", "expected tenures left over", exp_ops.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule